// File: doc/BRIEF.md
# High-Speed Data Lane Burst Sequencer

This block steers the line state of a single serial data lane through one high-speed burst. At rest the lane sits in the low-power stop state, with both lines high. A burst request is taken only when the clock lane has granted permission. The sequencer then steps down through two low-power entry states and enables the high-speed driver on a zero state. It places a sync word on the lane, then streams payload bytes taken from a valid/ready/last source. It closes the burst with a flat trailer that is the opposite of the final bit sent. Last, it parks the lane back in the stop state for a programmable exit time.

The length of every phase comes from a 16-bit configuration input counted in sequencer clock cycles. A programmed zero means one cycle. The byte leaving on `hs_byte` goes to a serializer that sends the least significant bit first, so the last bit of a byte is its bit 7. A separate check compares the programmed trailer plus a fixed pipeline latency against a programmed end-of-transmission limit and raises a flag when the limit would be broken.

Top module: `hsl_burst_seq`

## Requirements
- R1: A synchronous reset puts the lane in stop (`lp_pair` = 2'b11, where bit 1 is the positive line and bit 0 the negative line), with `hs_en`, `hs_byte`, `s_ready` and `underrun` all low.
- R2: A request is accepted only in the stop state and only while `burst_req` and `clk_grant` are both high. Without the grant the lane stays in stop. On acceptance the next cycle shows `lp_pair` = 2'b01.
- R3: The lane drives 2'b01 for max(lpx,1) cycles. It then drives 2'b00 with `hs_en` low for the larger of max(prepare,1) and max(lpx,1) cycles.
- R4: Next, `hs_en` rises with `hs_byte` = 0x00 for max(zero,1) cycles, followed by one cycle carrying the sync word 0xB8.
- R5: Payload bytes appear on `hs_byte` one per cycle in the order accepted, starting the cycle after the sync word. `s_ready` is high only during payload cycles. While `hs_en` is high, `lp_pair` is 2'b00.
- R6: After the last payload byte has been on the lane for one cycle, the lane drives the trailer for max(trail,1) cycles. In the trailer every bit of `hs_byte` equals the inverse of bit 7 of the last byte on the lane.
- R7: After the trailer, the lane drives 2'b11 for the larger of max(exit,1) and max(lpx,1) cycles and ignores `burst_req` during that time. A request held high is then taken one stop cycle later.
- R8: If `s_valid` is low during a payload cycle, `underrun` goes high and the trailer starts on the next cycle. The flag stays high until the next request is accepted.
- R9: One cycle after the configuration changes, `eot_err` is high exactly when max(trail,1) + EOT_LAT exceeds max(eot,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_req | input | 1 | Request to start a burst |
| clk_grant | input | 1 | Clock lane ready for data to start |
| cfg_lpx | input | DUR_W | Minimum length of any low-power state, in cycles |
| cfg_prepare | input | DUR_W | Length of the LP-00 bridge before high speed |
| cfg_zero | input | DUR_W | Length of the high-speed zero state before the sync word |
| cfg_trail | input | DUR_W | Length of the inverted trailer |
| cfg_exit | input | DUR_W | Length of the stop state after a burst |
| cfg_eot | input | DUR_W | End-of-transmission limit for the check |
| s_data | input | BYTE_W | Payload byte |
| s_valid | input | 1 | Payload byte valid |
| s_last | input | 1 | Payload byte is the final one |
| s_ready | output | 1 | Payload byte is taken this cycle if valid |
| lp_pair | output | 2 | Low-power line levels {positive, negative} |
| hs_en | output | 1 | High-speed driver enable |
| hs_byte | output | BYTE_W | Byte handed to the serializer |
| underrun | output | 1 | Payload source ran dry during a burst |
| eot_err | output | 1 | Trailer plus latency exceeds the end-of-transmission limit |

## Verification
Durations of zero are the first target. A design that counts a zero as zero cycles would skip a phase or wrap its counter and stall. The bench also programs a prepare time shorter than lpx and an exit time shorter than lpx; a design that ignores the low-power floor would shorten those states. Underruns are forced both before any payload byte and in mid-stream. When no byte has been sent, the trailer must follow the sync word's bit 7, and a design that picks the wrong byte gives the trailer the wrong polarity. A request is held high across a whole burst, and requests are raised without a grant. An early start, or an extra cycle spent in stop, shows up as a misplaced 2'b01 cycle.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    // Low-power line pair codes, {positive line, negative line}
    localparam logic [1:0] LP_STOP   = 2'b11;
    localparam logic [1:0] LP_REQ    = 2'b01;
    localparam logic [1:0] LP_BRIDGE = 2'b00;

    typedef enum logic [2:0] {
        ST_STOP,    // LP-11, waiting for request and grant
        ST_LPREQ,   // LP-01 entry step
        ST_BRIDGE,  // LP-00 before high speed
        ST_ZERO,    // HS-0
        ST_DATA,    // sync word then payload, source ready
        ST_FLUSH,   // final byte on the lane
        ST_TRAIL,   // inverted trailer
        ST_EXIT     // LP-11 recovery
    } lane_st_e;

endpackage

// File: rtl/hsl_dwell_timer.sv
module hsl_dwell_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // Lengths handed in are already floored to one cycle
    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    // An expired count must not wrap around
    p_hold_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/hsl_eot_guard.sv
module hsl_eot_guard #(
    parameter int W   = 16,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] trail_cyc,
    input  logic [W-1:0] eot_cyc,
    output logic         err
);

    localparam int SW = W + 2;

    logic [SW-1:0] need_w, room_w;
    logic          err_d, err_q;

    assign need_w = SW'(trail_cyc) + SW'(LAT);
    assign room_w = SW'(eot_cyc);

    always_comb begin
        err_d = (need_w > room_w);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_d;
    end

    assign err = err_q;

    // With both lengths floored, a trailer of at least the limit is always flagged
    p_floor_flag_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(trail_cyc) >= $past(eot_cyc) && $past(eot_cyc) != '0) |-> err_q);

endmodule

// File: rtl/hsl_burst_seq.sv
module hsl_burst_seq
    import hsl_pkg::*;
#(
    parameter int                DUR_W     = 16,
    parameter int                BYTE_W    = 8,
    parameter int                EOT_LAT   = 1,
    parameter logic [BYTE_W-1:0] SYNC_WORD = BYTE_W'(8'hB8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_req,
    input  logic              clk_grant,
    input  logic [DUR_W-1:0]  cfg_lpx,
    input  logic [DUR_W-1:0]  cfg_prepare,
    input  logic [DUR_W-1:0]  cfg_zero,
    input  logic [DUR_W-1:0]  cfg_trail,
    input  logic [DUR_W-1:0]  cfg_exit,
    input  logic [DUR_W-1:0]  cfg_eot,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [1:0]        lp_pair,
    output logic              hs_en,
    output logic [BYTE_W-1:0] hs_byte,
    output logic              underrun,
    output logic              eot_err
);

    typedef struct packed {
        lane_st_e          st;
        logic [BYTE_W-1:0] lane_byte;
        logic              uf;
    } seq_t;

    function automatic logic [DUR_W-1:0] floor1(input logic [DUR_W-1:0] v);
        return (v == '0) ? DUR_W'(1) : v;
    endfunction

    function automatic logic [DUR_W-1:0] lp_len(input logic [DUR_W-1:0] v,
                                                input logic [DUR_W-1:0] lpx);
        logic [DUR_W-1:0] a, b;
        a = floor1(v);
        b = floor1(lpx);
        return (a > b) ? a : b;
    endfunction

    logic [DUR_W-1:0] lpx_eff, prep_eff, zero_eff, trail_eff, exit_eff, eot_eff;

    assign lpx_eff   = floor1(cfg_lpx);
    assign prep_eff  = lp_len(cfg_prepare, cfg_lpx);
    assign zero_eff  = floor1(cfg_zero);
    assign trail_eff = floor1(cfg_trail);
    assign exit_eff  = lp_len(cfg_exit, cfg_lpx);
    assign eot_eff   = floor1(cfg_eot);

    seq_t             cur_d, cur_q;
    logic             tmr_load;
    logic [DUR_W-1:0] tmr_val;
    logic             tmr_done;

    hsl_dwell_timer #(.W(DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    hsl_eot_guard #(.W(DUR_W), .LAT(EOT_LAT)) u_eot (
        .clk       (clk),
        .rst       (rst),
        .trail_cyc (trail_eff),
        .eot_cyc   (eot_eff),
        .err       (eot_err)
    );

    always_comb begin
        cur_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = lpx_eff;
        unique case (cur_q.st)
            ST_STOP: begin
                if (burst_req && clk_grant) begin
                    cur_d.st = ST_LPREQ;
                    cur_d.uf = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = lpx_eff;
                end
            end
            ST_LPREQ: begin
                if (tmr_done) begin
                    cur_d.st = ST_BRIDGE;
                    tmr_load = 1'b1;
                    tmr_val  = prep_eff;
                end
            end
            ST_BRIDGE: begin
                if (tmr_done) begin
                    cur_d.st = ST_ZERO;
                    tmr_load = 1'b1;
                    tmr_val  = zero_eff;
                end
            end
            ST_ZERO: begin
                if (tmr_done) begin
                    cur_d.st        = ST_DATA;
                    cur_d.lane_byte = SYNC_WORD;
                end
            end
            ST_DATA: begin
                if (s_valid) begin
                    cur_d.lane_byte = s_data;
                    if (s_last) cur_d.st = ST_FLUSH;
                end else begin
                    cur_d.uf = 1'b1;
                    cur_d.st = ST_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = trail_eff;
                end
            end
            ST_FLUSH: begin
                cur_d.st = ST_TRAIL;
                tmr_load = 1'b1;
                tmr_val  = trail_eff;
            end
            ST_TRAIL: begin
                if (tmr_done) begin
                    cur_d.st = ST_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = exit_eff;
                end
            end
            ST_EXIT: begin
                if (tmr_done) cur_d.st = ST_STOP;
            end
            default: cur_d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st        <= ST_STOP;
            cur_q.lane_byte <= '0;
            cur_q.uf        <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    always_comb begin
        lp_pair = LP_BRIDGE;
        hs_en   = 1'b0;
        hs_byte = '0;
        unique case (cur_q.st)
            ST_STOP, ST_EXIT: lp_pair = LP_STOP;
            ST_LPREQ:         lp_pair = LP_REQ;
            ST_BRIDGE:        lp_pair = LP_BRIDGE;
            ST_ZERO:          hs_en   = 1'b1;
            ST_DATA, ST_FLUSH: begin
                hs_en   = 1'b1;
                hs_byte = cur_q.lane_byte;
            end
            ST_TRAIL: begin
                hs_en   = 1'b1;
                hs_byte = {BYTE_W{~cur_q.lane_byte[BYTE_W-1]}};
            end
            default: lp_pair = LP_STOP;
        endcase
    end

    assign s_ready  = (cur_q.st == ST_DATA);
    assign underrun = cur_q.uf;

    p_ready_in_hs_r5: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (hs_en && lp_pair == LP_BRIDGE));

    p_hs_bridge_r5: assert property (@(posedge clk) disable iff (rst)
        hs_en |-> (lp_pair == LP_BRIDGE));

    p_start_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (lp_pair == LP_REQ && $past(lp_pair) == LP_STOP) |-> $past(burst_req && clk_grant));

    p_underrun_trail_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_DATA && !s_valid) |=> (cur_q.st == ST_TRAIL && underrun));

    p_trail_flat_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_TRAIL) |-> (hs_byte == '0 || hs_byte == '1));

    p_trail_to_exit_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(cur_q.st) == ST_TRAIL && cur_q.st != ST_TRAIL) |-> (cur_q.st == ST_EXIT && lp_pair == LP_STOP));

endmodule

// File: tb/sim_hsl_burst_seq.sv
`timescale 1ns/1ps
module sim_hsl_burst_seq;

    logic        clk = 1'b0;
    logic        rst, burst_req, clk_grant;
    logic [15:0] cfg_lpx, cfg_prepare, cfg_zero, cfg_trail, cfg_exit, cfg_eot;
    logic [7:0]  s_data;
    logic        s_valid, s_last;
    logic        s_ready, hs_en, underrun, eot_err;
    logic [1:0]  lp_pair;
    logic [7:0]  hs_byte;

    always #2 clk = ~clk;

    hsl_burst_seq u0 (
        .clk(clk), .rst(rst), .burst_req(burst_req), .clk_grant(clk_grant),
        .cfg_lpx(cfg_lpx), .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_exit(cfg_exit), .cfg_eot(cfg_eot),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .lp_pair(lp_pair), .hs_en(hs_en), .hs_byte(hs_byte),
        .underrun(underrun), .eot_err(eot_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [1:0] q_lp[$];
    bit         q_hs[$];
    logic [7:0] q_b[$];
    bit         q_rdy[$];
    string      q_tag[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int lplen(input int v, input int l);
        return (eff(v) > eff(l)) ? eff(v) : eff(l);
    endfunction

    task automatic push(input logic [1:0] lp, input bit hs, input logic [7:0] b, input bit rdy, input string tag);
        q_lp.push_back(lp); q_hs.push_back(hs); q_b.push_back(b);
        q_rdy.push_back(rdy); q_tag.push_back(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; burst_req = 1'b0; s_valid = 1'b0; s_last = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(lp_pair == 2'b11, "R1 reset lp_pair", 32'(lp_pair), 32'h3);
        check(hs_en == 1'b0, "R1 reset hs_en", 32'(hs_en), 0);
        check(hs_byte == 8'h00, "R1 reset hs_byte", 32'(hs_byte), 0);
        check(s_ready == 1'b0, "R1 reset s_ready", 32'(s_ready), 0);
        check(underrun == 1'b0, "R1 reset underrun", 32'(underrun), 0);
    endtask

    task automatic run_burst(input int lpx, input int prep, input int zero, input int trail,
                             input int exitv, input int n, input int uf_at, input bit hold);
        logic [7:0] pl[16];
        logic [7:0] lastb;
        int m;
        int trail_idx;
        for (int i = 0; i < n; i++) pl[i] = 8'($urandom);
        cfg_lpx = 16'(lpx); cfg_prepare = 16'(prep); cfg_zero = 16'(zero);
        cfg_trail = 16'(trail); cfg_exit = 16'(exitv);
        q_lp.delete(); q_hs.delete(); q_b.delete(); q_rdy.delete(); q_tag.delete();
        repeat (eff(lpx)) push(2'b01, 1'b0, 8'h00, 1'b0, "R3 entry 01");
        repeat (lplen(prep, lpx)) push(2'b00, 1'b0, 8'h00, 1'b0, "R3 bridge 00");
        repeat (eff(zero)) push(2'b00, 1'b1, 8'h00, 1'b0, "R4 hs zero");
        push(2'b00, 1'b1, 8'hB8, 1'b1, "R4 sync");
        m = (uf_at >= 0) ? uf_at : n;
        for (int i = 0; i < m; i++)
            push(2'b00, 1'b1, pl[i], (uf_at >= 0) ? 1'b1 : (i < n - 1), "R5 payload");
        lastb = (m == 0) ? 8'hB8 : pl[m-1];
        trail_idx = q_lp.size();
        repeat (eff(trail)) push(2'b00, 1'b1, {8{~lastb[7]}}, 1'b0, "R6 trail");
        repeat (lplen(exitv, lpx)) push(2'b11, 1'b0, 8'h00, 1'b0, "R7 exit 11");
        push(2'b11, 1'b0, 8'h00, 1'b0, "R7 stop 11");
        if (hold) push(2'b01, 1'b0, 8'h00, 1'b0, "R7 restart");

        @(negedge clk);
        burst_req = 1'b1; clk_grant = 1'b1;
        fork
            begin
                int idx;
                bit fin;
                idx = 0; fin = 0;
                while (!fin) begin
                    @(negedge clk);
                    if (uf_at >= 0 && idx == uf_at) begin
                        s_valid = 1'b0; s_last = 1'b0;
                        if (s_ready) fin = 1;
                    end else begin
                        s_valid = 1'b1; s_data = pl[idx]; s_last = (idx == n - 1);
                        if (s_ready) begin
                            if (idx == n - 1) fin = 1;
                            idx++;
                        end
                    end
                end
                @(negedge clk);
                s_valid = 1'b0; s_last = 1'b0;
            end
            begin
                for (int i = 0; i < q_lp.size(); i++) begin
                    @(negedge clk);
                    if (!hold && i == 0) burst_req = 1'b0;
                    check(lp_pair == q_lp[i], q_tag[i], 32'(lp_pair), 32'(q_lp[i]));
                    check(hs_en == q_hs[i], q_tag[i], 32'(hs_en), 32'(q_hs[i]));
                    check(hs_byte == q_b[i], q_tag[i], 32'(hs_byte), 32'(q_b[i]));
                    check(s_ready == q_rdy[i], "R5 ready window", 32'(s_ready), 32'(q_rdy[i]));
                    if (i == trail_idx)
                        check(underrun == (uf_at >= 0), "R8 underrun flag", 32'(underrun), 32'(uf_at >= 0));
                end
            end
        join
        if (hold) begin
            do_reset();
        end else begin
            repeat (3) begin
                @(negedge clk);
                check(lp_pair == 2'b11 && !hs_en, "R7 idle stop", 32'(lp_pair), 32'h3);
            end
        end
    endtask

    task automatic eot_case(input int t, input int e);
        bit exp;
        cfg_trail = 16'(t); cfg_eot = 16'(e);
        exp = (eff(t) + 1) > eff(e);
        repeat (2) @(negedge clk);
        check(eot_err == exp, "R9 eot flag", 32'(eot_err), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1-flow: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        rst = 1'b1; burst_req = 1'b0; clk_grant = 1'b0;
        s_valid = 1'b0; s_last = 1'b0; s_data = 8'h00;
        cfg_lpx = 16'd1; cfg_prepare = 16'd1; cfg_zero = 16'd1;
        cfg_trail = 16'd1; cfg_exit = 16'd1; cfg_eot = 16'd100;
        do_reset();

        // R3 R4 R6 R7: all durations zero behave as one cycle, single byte
        run_burst(0, 0, 0, 0, 0, 1, -1, 1'b0);
        // R3 R7: prepare and exit shorter than lpx, request held through burst
        run_burst(4, 1, 3, 2, 0, 4, -1, 1'b1);
        // R8 R6: underrun before any payload byte, trailer follows sync bit 7
        run_burst(2, 3, 2, 3, 5, 5, 0, 1'b0);
        // R8: underrun in mid-stream
        run_burst(1, 2, 1, 1, 2, 6, 3, 1'b0);
        // R8: flag cleared by next accepted request
        run_burst(1, 1, 1, 1, 1, 3, -1, 1'b0);

        // R2: no grant, no start
        @(negedge clk);
        burst_req = 1'b1; clk_grant = 1'b0;
        repeat (8) begin
            @(negedge clk);
            check(lp_pair == 2'b11 && !hs_en, "R2 held without grant", 32'(lp_pair), 32'h3);
        end
        burst_req = 1'b0; clk_grant = 1'b1;
        run_burst(2, 2, 2, 2, 2, 2, -1, 1'b0);

        // R9: end-of-transmission flag
        eot_case(5, 5);
        eot_case(5, 6);
        eot_case(0, 0);
        eot_case(0, 2);
        eot_case(9, 3);
        for (int k = 0; k < 6; k++) eot_case(int'($urandom_range(0, 20)), int'($urandom_range(0, 20)));
        cfg_eot = 16'd100;

        // Constrained random bursts
        for (int k = 0; k < 25; k++) begin
            int n, uf;
            n  = int'($urandom_range(1, 12));
            uf = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, n - 1)) : -1;
            run_burst(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                      int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                      int'($urandom_range(0, 5)), n, uf, ($urandom_range(0, 4) == 0));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule